// File: doc/BRIEF.md
# Banked Data Memory Addressing Unit

This block sits beside the ALU of an 8-bit accumulator-style core. It turns the file operand of an instruction into a 12-bit physical data address and performs the read or write that goes with it. There are three ways to form the address. A banked direct access puts a 4-bit bank number in front of the 8-bit file field. An access-window direct access reaches the low half of bank 0 and the special-function area at the top of the map, and it ignores the bank number. An indirect access takes the whole 12-bit address from one of two pointer registers.

Reads are combinational from the formed address, so the ALU sees its operand in the same cycle. The result of the operation comes back on `aluResult`. A destination bit then steers it either into the working register or back into the addressed location, and the write takes place on the next rising clock edge. The bank number and the two pointers are registers mapped into the special-function area. Software loads them with ordinary file writes. The rest of the special-function area is plain storage.

Top module: `bank_addr_unit`

## Requirements
- R1: With `indirSel`=0 and `accessSel`=0, `physAddr` is the bank register value in bits 11:8 and `fileAddr` in bits 7:0.
- R2: With `indirSel`=0, `accessSel`=1 and `fileAddr` below 0x80, `physAddr` is 0x000 plus `fileAddr`, whatever the bank register holds.
- R3: With `indirSel`=0, `accessSel`=1 and `fileAddr` of 0x80 or above, `physAddr` is 0xF00 plus `fileAddr`, which lands in the special-function area 0xF80–0xFFF.
- R4: With `indirSel`=1, `physAddr` is pointer 0 when `ptrSel`=0 and pointer 1 when `ptrSel`=1, and `fileAddr` and `accessSel` have no effect.
- R5: `rdData` shows the byte at `physAddr` in the same cycle, with no clock edge in between.
- R6: When `wrEn`=1 and `destFile`=1, `aluResult` is stored at `physAddr` on the rising edge. When `wrEn`=1 and `destFile`=0, it goes into the working register and the file location does not change.
- R7: The bank register sits at physical 0xFE0 and keeps the low 4 bits of a write. It reads back with bits 7:4 as zero and resets to zero.
- R8: The pointers are 12 bits wide and are stored low byte first: pointer 0 at 0xFE4 (low) and 0xFE5 (high), pointer 1 at 0xFE6 (low) and 0xFE7 (high). A high byte keeps bits 11:8 in its low nibble and reads back with bits 7:4 as zero. Both pointers reset to zero.
- R9: Addresses from the end of the implemented RAM (`RAM_BANKS`×256, 0x400 by default) up to 0xF7F read as zero, and writes to them are dropped.
- R10: `wregOut` shows the working register, which resets to zero.
- R11: With `wrEn`=0, neither memory nor the working register nor the bank and pointer registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| fileAddr | input | 8 | File operand field of the instruction |
| accessSel | input | 1 | 1 = access window, 0 = banked direct access |
| indirSel | input | 1 | 1 = take the address from a pointer register |
| ptrSel | input | 1 | Pointer choice for indirect access |
| wrEn | input | 1 | Commit the operation result this cycle |
| destFile | input | 1 | 1 = result to the file location, 0 = to the working register |
| aluResult | input | 8 | Result to be written |
| physAddr | output | 12 | Formed physical data address |
| rdData | output | 8 | Byte at the formed address |
| wregOut | output | 8 | Working register contents |

## Verification
If the bank or pointer state is wrong, `physAddr` goes wrong at once, in the first cycle that uses that state. `rdData` then returns the byte from another location, so one read after a register load exposes the fault. A write that lands in the wrong place, or that should have been dropped, shows up only on a later read of the address it should or should not have reached. For that reason the sequences write a location and read it back through a second addressing mode. Faults in the working register show on `wregOut` one cycle after the commit.

// File: rtl/bau_pkg.sv
package bau_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 8;
  localparam int BANK_W  = 4;
  localparam int NUM_PTR = 2;
  localparam int PTR_IW  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  // special-function area and the mapped control registers
  localparam logic [ADDR_W-1:0] SFR_BASE      = 12'hF80;
  localparam logic [ADDR_W-1:0] BANK_REG_ADDR = 12'hFE0;
  localparam logic [ADDR_W-1:0] PTR_BASE_ADDR = 12'hFE4;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_SFR,
    TGT_BANK,
    TGT_PTR_LO,
    TGT_PTR_HI
  } target_e;

  // strobes from control to datapath
  typedef struct packed {
    target_e               target;
    logic [PTR_IW-1:0]     ptrIdx;
    logic                  fileWe;
    logic                  wregWe;
    logic [ADDR_W-1:0]     addr;
  } ctrl_strobe_t;
endpackage

// File: rtl/bau_ctrl.sv
module bau_ctrl
  import bau_pkg::*;
#(
  parameter int RAM_BANKS = 4
) (
  input  logic [7:0]        fileAddr,
  input  logic              accessSel,
  input  logic              indirSel,
  input  logic              ptrSel,
  input  logic              wrEn,
  input  logic              destFile,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] ptrVal [NUM_PTR],
  output ctrl_strobe_t      strobe,
  output logic [ADDR_W-1:0] physAddr
);
  localparam logic [ADDR_W:0] RAM_LIMIT = (ADDR_W+1)'(RAM_BANKS * 256);

  logic [ADDR_W-1:0] formed;
  target_e           tgt;
  logic [PTR_IW-1:0] idx;

  // address formation: pointer, access window or bank prefix
  always_comb begin
    if (indirSel) begin
      formed = ptrVal[PTR_IW'(ptrSel)];
    end else if (accessSel) begin
      formed = fileAddr[7] ? {4'hF, fileAddr} : {4'h0, fileAddr};
    end else begin
      formed = {bankSel, fileAddr};
    end
  end

  // target decode
  always_comb begin
    tgt = TGT_NONE;
    idx = '0;
    if (formed == BANK_REG_ADDR) begin
      tgt = TGT_BANK;
    end else if (formed >= SFR_BASE) begin
      tgt = TGT_SFR;
      for (int i = 0; i < NUM_PTR; i++) begin
        if (formed == PTR_BASE_ADDR + ADDR_W'(2*i)) begin
          tgt = TGT_PTR_LO;
          idx = PTR_IW'(i);
        end else if (formed == PTR_BASE_ADDR + ADDR_W'(2*i + 1)) begin
          tgt = TGT_PTR_HI;
          idx = PTR_IW'(i);
        end
      end
    end else if ({1'b0, formed} < RAM_LIMIT) begin
      tgt = TGT_RAM;
    end
  end

  always_comb begin
    strobe.target = tgt;
    strobe.ptrIdx = idx;
    strobe.fileWe = wrEn && destFile && (tgt != TGT_NONE);
    strobe.wregWe = wrEn && !destFile;
    strobe.addr   = formed;
  end

  assign physAddr = formed;
endmodule

// File: rtl/bau_datapath.sv
module bau_datapath
  import bau_pkg::*;
#(
  parameter int RAM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [BANK_W-1:0] bankSel,
  output logic [ADDR_W-1:0] ptrVal [NUM_PTR],
  output logic [DATA_W-1:0] wregOut
);
  localparam int RAM_BYTES = RAM_BANKS * 256;
  localparam int RAM_AW    = $clog2(RAM_BYTES);
  localparam int SFR_BYTES = 128;
  localparam int SFR_AW    = $clog2(SFR_BYTES);
  localparam int HI_W      = ADDR_W - DATA_W;

  logic [DATA_W-1:0] ramMem [RAM_BYTES];
  logic [DATA_W-1:0] sfrMem [SFR_BYTES];
  logic [BANK_W-1:0] bankQ;
  logic [DATA_W-1:0] wregQ;
  logic [ADDR_W-1:0] ptrQ [NUM_PTR];
  logic              unusedAddr;

  assign unusedAddr = &{1'b0, strobe.addr};

  always_ff @(posedge clk) begin
    if (strobe.fileWe && strobe.target == TGT_RAM)
      ramMem[strobe.addr[RAM_AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.fileWe && strobe.target == TGT_SFR)
      sfrMem[strobe.addr[SFR_AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bankQ <= '0;
    else if (strobe.fileWe && strobe.target == TGT_BANK)
      bankQ <= wrData[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wregQ <= '0;
    else if (strobe.wregWe)
      wregQ <= wrData;
  end

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic hit;
    assign hit = strobe.fileWe && (strobe.ptrIdx == PTR_IW'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ[g] <= '0;
      end else if (hit && strobe.target == TGT_PTR_LO) begin
        ptrQ[g][DATA_W-1:0] <= wrData;
      end else if (hit && strobe.target == TGT_PTR_HI) begin
        ptrQ[g][ADDR_W-1:DATA_W] <= wrData[HI_W-1:0];
      end
    end
    assign ptrVal[g] = ptrQ[g];
  end

  always_comb begin
    unique case (strobe.target)
      TGT_RAM:    rdData = ramMem[strobe.addr[RAM_AW-1:0]];
      TGT_SFR:    rdData = sfrMem[strobe.addr[SFR_AW-1:0]];
      TGT_BANK:   rdData = {{(DATA_W-BANK_W){1'b0}}, bankQ};
      TGT_PTR_LO: rdData = ptrQ[strobe.ptrIdx][DATA_W-1:0];
      TGT_PTR_HI: rdData = {{(DATA_W-HI_W){1'b0}}, ptrQ[strobe.ptrIdx][ADDR_W-1:DATA_W]};
      default:    rdData = '0;
    endcase
  end

  assign bankSel = bankQ;
  assign wregOut = wregQ;
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
  import bau_pkg::*;
#(
  parameter int RAM_BANKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  fileAddr,
  input  logic        accessSel,
  input  logic        indirSel,
  input  logic        ptrSel,
  input  logic        wrEn,
  input  logic        destFile,
  input  logic [7:0]  aluResult,
  output logic [11:0] physAddr,
  output logic [7:0]  rdData,
  output logic [7:0]  wregOut
);
  ctrl_strobe_t      strobe;
  logic [BANK_W-1:0] bankSel;
  logic [ADDR_W-1:0] ptrVal [NUM_PTR];

  bau_ctrl #(.RAM_BANKS(RAM_BANKS)) ctrl_i (
    .fileAddr (fileAddr),
    .accessSel(accessSel),
    .indirSel (indirSel),
    .ptrSel   (ptrSel),
    .wrEn     (wrEn),
    .destFile (destFile),
    .bankSel  (bankSel),
    .ptrVal   (ptrVal),
    .strobe   (strobe),
    .physAddr (physAddr)
  );

  bau_datapath #(.RAM_BANKS(RAM_BANKS)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (aluResult),
    .rdData (rdData),
    .bankSel(bankSel),
    .ptrVal (ptrVal),
    .wregOut(wregOut)
  );
endmodule

// File: rtl/bau_checker.sv
module bau_checker #(
  parameter int RAM_BANKS = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  fileAddr,
  input logic        accessSel,
  input logic        indirSel,
  input logic        wrEn,
  input logic        destFile,
  input logic [7:0]  aluResult,
  input logic [11:0] physAddr,
  input logic [7:0]  rdData,
  input logic [7:0]  wregOut,
  input logic [3:0]  bankSel
);
  localparam logic [12:0] RAM_LIMIT = 13'(RAM_BANKS * 256);

  a_r1_banked_prefix: assert property (@(posedge clk) disable iff (!rstN)
    (!indirSel && !accessSel) |-> (physAddr[11:8] == bankSel && physAddr[7:0] == fileAddr));

  a_r2_access_low: assert property (@(posedge clk) disable iff (!rstN)
    (!indirSel && accessSel && !fileAddr[7]) |-> (physAddr[11:8] == 4'h0));

  a_r3_access_high: assert property (@(posedge clk) disable iff (!rstN)
    (!indirSel && accessSel && fileAddr[7]) |-> (physAddr[11:8] == 4'hF));

  a_r7_bank_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && destFile && physAddr == 12'hFE0) |=> (bankSel == $past(aluResult[3:0])));

  a_r9_gap_zero: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, physAddr} >= RAM_LIMIT && physAddr < 12'hF80) |-> (rdData == 8'h00));

  a_r10_wreg_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !destFile) |=> (wregOut == $past(aluResult)));

  a_r11_wreg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && !destFile) |=> $stable(wregOut));

  a_r11_bank_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(bankSel));
endmodule

bind bank_addr_unit bau_checker #(.RAM_BANKS(RAM_BANKS)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .fileAddr (fileAddr),
  .accessSel(accessSel),
  .indirSel (indirSel),
  .wrEn     (wrEn),
  .destFile (destFile),
  .aluResult(aluResult),
  .physAddr (physAddr),
  .rdData   (rdData),
  .wregOut  (wregOut),
  .bankSel  (bankSel)
);

// File: tb/bank_addr_unit_tb_top.sv
module bank_addr_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAM_BANKS  = 4;
  localparam int RAM_LIMIT  = RAM_BANKS * 256;

  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  fileAddr = 0;
  logic        accessSel = 0, indirSel = 0, ptrSel = 0, wrEn = 0, destFile = 0;
  logic [7:0]  aluResult = 0;
  logic [11:0] physAddr;
  logic [7:0]  rdData, wregOut;

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct {
    logic [11:0] addr;
    logic [7:0]  rd;
    bit          chkRd;
    logic [7:0]  w;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  // reference state
  logic [7:0]  mMem [int];
  logic [3:0]  mBank = 0;
  logic [11:0] mPtr [2] = '{12'h0, 12'h0};
  logic [7:0]  mW = 0;

  bank_addr_unit #(.RAM_BANKS(RAM_BANKS)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] formAddr(logic [7:0] f, bit acc, bit ind, bit ps);
    if (ind) return mPtr[ps];
    if (acc) return f[7] ? {4'hF, f} : {4'h0, f};
    return {mBank, f};
  endfunction

  function automatic bit knownRead(logic [11:0] a, output logic [7:0] v);
    v = 8'h00;
    if (a == 12'hFE0) begin v = {4'h0, mBank}; return 1; end
    if (a == 12'hFE4) begin v = mPtr[0][7:0]; return 1; end
    if (a == 12'hFE5) begin v = {4'h0, mPtr[0][11:8]}; return 1; end
    if (a == 12'hFE6) begin v = mPtr[1][7:0]; return 1; end
    if (a == 12'hFE7) begin v = {4'h0, mPtr[1][11:8]}; return 1; end
    if (a >= RAM_LIMIT && a < 12'hF80) return 1;
    if (mMem.exists(int'(a))) begin v = mMem[int'(a)]; return 1; end
    return 0;
  endfunction

  function automatic void modelWrite(logic [11:0] a, logic [7:0] d);
    if (a == 12'hFE0) mBank = d[3:0];
    else if (a == 12'hFE4) mPtr[0][7:0] = d;
    else if (a == 12'hFE5) mPtr[0][11:8] = d[3:0];
    else if (a == 12'hFE6) mPtr[1][7:0] = d;
    else if (a == 12'hFE7) mPtr[1][11:8] = d[3:0];
    else if (a < RAM_LIMIT || a >= 12'hF80) mMem[int'(a)] = d;
  endfunction

  // driver: one operation per cycle, pushes what the ports must show
  task automatic op(logic [7:0] f, bit acc, bit ind, bit ps, bit we, bit dst,
                    logic [7:0] val, string tag);
    exp_t e;
    logic [7:0] rv;
    @(negedge clk);
    fileAddr = f; accessSel = acc; indirSel = ind; ptrSel = ps;
    wrEn = we; destFile = dst; aluResult = val;
    e.addr  = formAddr(f, acc, ind, ps);
    e.chkRd = knownRead(e.addr, rv);
    e.rd    = rv;
    e.w     = mW;
    e.tag   = tag;
    expQ.push_back(e);
    if (we && dst) modelWrite(e.addr, val);
    if (we && !dst) mW = val;
  endtask

  task automatic check(bit ok, string tag, string what, int act, int expv);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  // monitor: compare every queued item against the ports before the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(physAddr == e.addr, e.tag, "physAddr", physAddr, e.addr);
        if (e.chkRd) check(rdData == e.rd, e.tag, "rdData", rdData, e.rd);
        check(wregOut == e.w, e.tag, "wregOut", wregOut, e.w);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // reset state: R7 bank, R8 pointers, R10 working register
    op(8'hE0, 1, 0, 0, 0, 0, 8'h00, "R7 reset bank");
    op(8'hE4, 1, 0, 0, 0, 0, 8'h00, "R8 reset ptr0 lo");
    op(8'hE7, 1, 0, 0, 0, 0, 8'h00, "R8 reset ptr1 hi");
    op(8'h00, 0, 0, 0, 0, 0, 8'h00, "R10 reset wreg");
    // R7: load bank 1, upper nibble dropped
    op(8'hE0, 1, 0, 0, 1, 1, 8'h31, "R7 bank write");
    op(8'hE0, 1, 0, 0, 0, 0, 8'h00, "R7 bank readback");
    // R1/R5/R6: banked write and same-cycle read
    op(8'h22, 0, 0, 0, 1, 1, 8'hA5, "R1 banked write 0x122");
    op(8'h22, 0, 0, 0, 0, 0, 8'h00, "R5 banked read 0x122");
    // R2: access window low ignores bank
    op(8'h22, 1, 0, 0, 1, 1, 8'h5C, "R2 access low write 0x022");
    op(8'h22, 1, 0, 0, 0, 0, 8'h00, "R2 access low read");
    op(8'h22, 0, 0, 0, 0, 0, 8'h00, "R1 bank 1 still distinct");
    op(8'hE0, 1, 0, 0, 1, 1, 8'h00, "R7 bank to 0");
    op(8'h22, 0, 0, 0, 0, 0, 8'h00, "R1 bank 0 aliases window");
    // R8: pointer loads, low byte then high byte
    op(8'hE4, 1, 0, 0, 1, 1, 8'h22, "R8 ptr0 lo");
    op(8'hE5, 1, 0, 0, 1, 1, 8'hF1, "R8 ptr0 hi");
    op(8'hE5, 1, 0, 0, 0, 0, 8'h00, "R8 ptr0 hi readback");
    op(8'hE6, 1, 0, 0, 1, 1, 8'h22, "R8 ptr1 lo");
    // R4: indirect, fileAddr and accessSel ignored
    op(8'h9D, 1, 1, 0, 0, 0, 8'h00, "R4 indirect ptr0");
    op(8'h13, 0, 1, 1, 0, 0, 8'h00, "R4 indirect ptr1");
    op(8'h40, 0, 1, 1, 1, 1, 8'h77, "R4 indirect write ptr1");
    op(8'h22, 1, 0, 0, 0, 0, 8'h00, "R6 indirect write seen direct");
    // R3: access high into special-function area
    op(8'h90, 1, 0, 0, 1, 1, 8'h3C, "R3 access high write 0xF90");
    op(8'h90, 1, 0, 0, 0, 0, 8'h00, "R3 access high read");
    op(8'hE0, 1, 0, 0, 1, 1, 8'h0F, "R7 bank to F");
    op(8'h90, 0, 0, 0, 0, 0, 8'h00, "R3 bank F reaches same byte");
    // R9: gap region
    op(8'hE5, 1, 0, 0, 1, 1, 8'h08, "R9 ptr0 hi to gap");
    op(8'hE4, 1, 0, 0, 1, 1, 8'h00, "R9 ptr0 lo to gap");
    op(8'h00, 0, 1, 0, 1, 1, 8'hEE, "R9 gap write dropped");
    op(8'h00, 0, 1, 0, 0, 0, 8'h00, "R9 gap reads zero");
    op(8'hE0, 1, 0, 0, 1, 1, 8'h05, "R9 bank 5");
    op(8'h10, 0, 0, 0, 0, 0, 8'h00, "R9 banked gap zero");
    // R6: destination W leaves memory alone
    op(8'h22, 1, 0, 0, 1, 0, 8'h99, "R6 dest W");
    op(8'h22, 1, 0, 0, 0, 0, 8'h00, "R6 memory unchanged, W loaded");
    // R11: no commit without wrEn
    op(8'h22, 1, 0, 0, 0, 1, 8'h12, "R11 no write file");
    op(8'hE0, 1, 0, 0, 0, 1, 8'h0A, "R11 no write bank");
    op(8'h22, 1, 0, 0, 0, 0, 8'h00, "R11 file unchanged");
    op(8'hE0, 1, 0, 0, 0, 0, 8'h00, "R11 bank unchanged");
    op(8'h00, 0, 0, 0, 0, 0, 8'h00, "R10 wreg held");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule